// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block decides which processor agents an interrupt message is addressed to. A request arrives as a pair of 32-bit command words and a strobe. The block takes the destination byte, the physical/logical selector, the delivery mode and the destination shorthand from fixed fields of those words. Each agent supplies its own ID byte, its logical destination byte and a 4-bit destination model, all as static inputs. The block matches every agent in parallel and registers an N-bit delivery mask.

In physical mode an agent is addressed by its ID, and destination 0xFF reaches every agent. In logical mode each agent applies its own model: flat matching ANDs the destination with the agent's logical byte, while cluster matching compares the upper nibbles and ANDs the lower nibbles. A shorthand can override the destination entirely and address the sender, everyone, or everyone except the sender. For lowest-priority delivery the block also reports one chosen agent, which is the lowest-indexed member of the mask. It does not inject interrupts and does not arbitrate on priority.

Top module: `irqdst_resolver`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. `out_mask`, `out_pick_valid` and `out_pick_idx` load only on a strobe and hold their values while `req_valid` is low.
- R2: Physical mode (`cmd_lo[11]`=0, shorthand 0) with destination 0xFF addresses all agents.
- R3: In physical mode, any other destination addresses only the lowest-indexed agent whose ID equals the destination. If no ID matches, no agent is addressed.
- R4: Logical mode (`cmd_lo[11]`=1, shorthand 0) addresses an agent whose model is 4'hF (flat) when the destination AND the agent's logical byte is nonzero.
- R5: Logical mode addresses an agent whose model is 4'h0 (cluster) when bits 7:4 of the destination and of the logical byte are equal and bits 3:0 of the two share at least one set bit.
- R6: In logical mode, an agent whose model is neither 4'hF nor 4'h0 is never addressed.
- R7: Shorthand 1 addresses only the agent `sender_idx`, whatever the destination and mode fields hold.
- R8: Shorthand 2 addresses all agents. Shorthand 3 addresses all agents except `sender_idx`.
- R9: The shorthand is taken from `cmd_lo[19:18]`, the delivery mode from `cmd_lo[10:8]`, the mode bit from `cmd_lo[11]` and the destination from `cmd_hi[31:24]`. All other command bits are ignored.
- R10: When the delivery mode is 3'b001 (lowest priority) and the mask is not empty, `out_pick_valid` is 1 and `out_pick_idx` is the lowest set index of the mask. When the mask is empty, or for any other delivery mode, `out_pick_valid` is 0 and `out_pick_idx` is 0.
- R11: While `rst` is high, all outputs go to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per message |
| cmd_lo | input | 32 | Low command word (shorthand, mode, delivery mode) |
| cmd_hi | input | 32 | High command word (destination byte) |
| sender_idx | input | IDX_W | Index of the sending agent |
| agent_id | input | NUM_AGENTS*8 | Agent IDs, agent k at bits 8k+7:8k |
| agent_ldest | input | NUM_AGENTS*8 | Agent logical destination bytes, same packing |
| agent_model | input | NUM_AGENTS*4 | Agent destination models, agent k at bits 4k+3:4k |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_mask | output | NUM_AGENTS | Delivery bitmask, bit k addresses agent k |
| out_pick_valid | output | 1 | Lowest-priority choice present |
| out_pick_idx | output | IDX_W | Chosen agent for lowest-priority delivery |

## Verification
The inline properties check the following on every cycle: the strobe-to-valid timing, the holding of results between strobes, the single-agent result of physical unicast, the shape of the three shorthand overrides, and that the chosen agent is the lowest member of the mask and appears only for lowest-priority delivery. The flat and cluster comparisons, the exclusion of unknown models, duplicate IDs and the exact field positions can only be shown by the bench. It drives scenarios against a fixed set of agent configurations and compares each result with its own reference model.

// File: rtl/irqdst_pkg.sv
package irqdst_pkg;

    localparam int DEST_W  = 8;
    localparam int MODEL_W = 4;

    localparam logic [DEST_W-1:0]  PHYS_BCAST    = 8'hFF;
    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } deliv_e;

    typedef struct packed {
        shorthand_e        sh;
        deliv_e            dm;
        logic              logical;
        logic [DEST_W-1:0] dest;
    } req_t;

    // Extract the routing fields from the two command words.
    function automatic req_t decode_cmd(input logic [31:0] lo, input logic [31:0] hi);
        req_t r;
        r.sh      = shorthand_e'(lo[19:18]);
        r.dm      = deliv_e'(lo[10:8]);
        r.logical = lo[11];
        r.dest    = hi[31:24];
        return r;
    endfunction

    // Logical match of one agent under its own destination model.
    function automatic logic logical_hit(input logic [DEST_W-1:0]  dest,
                                         input logic [DEST_W-1:0]  ldest,
                                         input logic [MODEL_W-1:0] model);
        logic [DEST_W-1:0] both;
        both = dest & ldest;
        if (model == MODEL_FLAT)
            return |both;
        else if (model == MODEL_CLUSTER)
            return (dest[7:4] == ldest[7:4]) && (|both[3:0]);
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/irqdst_lowest.sv
module irqdst_lowest #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqdst_match.sv
module irqdst_match
    import irqdst_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 logical,
    input  logic [DEST_W-1:0]    dest,
    input  logic [N*DEST_W-1:0]  ids,
    input  logic [N*DEST_W-1:0]  ldests,
    input  logic [N*MODEL_W-1:0] models,
    output logic [N-1:0]         hit
);
    logic [N-1:0]     id_eq;
    logic [N-1:0]     log_hit;
    logic [N-1:0]     phys_one;
    logic             phys_any;
    logic [IDX_W-1:0] phys_idx;

    for (genvar g = 0; g < N; g++) begin : g_agent
        assign id_eq[g]   = (ids[g*DEST_W +: DEST_W] == dest);
        assign log_hit[g] = logical_hit(dest, ldests[g*DEST_W +: DEST_W],
                                        models[g*MODEL_W +: MODEL_W]);
    end

    // Physical unicast resolves duplicate IDs to the lowest index.
    irqdst_lowest #(.N(N), .IDX_W(IDX_W)) u_phys (
        .vec (id_eq),
        .any (phys_any),
        .idx (phys_idx)
    );

    assign phys_one = phys_any ? (N'(1) << phys_idx) : '0;

    always_comb begin
        if (logical)
            hit = log_hit;
        else if (dest == PHYS_BCAST)
            hit = '1;
        else
            hit = phys_one;
    end
endmodule

// File: rtl/irqdst_resolver.sv
module irqdst_resolver
    import irqdst_pkg::*;
#(
    parameter int NUM_AGENTS = 8,
    parameter int IDX_W      = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [31:0]                   cmd_lo,
    input  logic [31:0]                   cmd_hi,
    input  logic [IDX_W-1:0]              sender_idx,
    input  logic [NUM_AGENTS*DEST_W-1:0]  agent_id,
    input  logic [NUM_AGENTS*DEST_W-1:0]  agent_ldest,
    input  logic [NUM_AGENTS*MODEL_W-1:0] agent_model,
    output logic                          out_valid,
    output logic [NUM_AGENTS-1:0]         out_mask,
    output logic                          out_pick_valid,
    output logic [IDX_W-1:0]              out_pick_idx
);
    localparam int N = NUM_AGENTS;

    req_t             rq;
    logic [N-1:0]     dest_hit;
    logic [N-1:0]     self_vec;
    logic [N-1:0]     sel_mask;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    assign rq = decode_cmd(cmd_lo, cmd_hi);

    irqdst_match #(.N(N), .IDX_W(IDX_W)) u_match (
        .logical (rq.logical),
        .dest    (rq.dest),
        .ids     (agent_id),
        .ldests  (agent_ldest),
        .models  (agent_model),
        .hit     (dest_hit)
    );

    assign self_vec = N'(1) << sender_idx;

    always_comb begin
        unique case (rq.sh)
            SH_NONE:   sel_mask = dest_hit;
            SH_SELF:   sel_mask = self_vec;
            SH_ALL:    sel_mask = '1;
            SH_OTHERS: sel_mask = ~self_vec;
            default:   sel_mask = '0;
        endcase
    end

    irqdst_lowest #(.N(N), .IDX_W(IDX_W)) u_pick (
        .vec (sel_mask),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_mask       <= '0;
            out_pick_valid <= 1'b0;
            out_pick_idx   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_mask       <= sel_mask;
                out_pick_valid <= (rq.dm == DM_LOWEST) && pick_any;
                out_pick_idx   <= ((rq.dm == DM_LOWEST) && pick_any) ? pick_idx : '0;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    // R1
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(out_mask) && $stable(out_pick_valid) && $stable(out_pick_idx)));
    // R3
    phys_single_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rq.sh == SH_NONE && !rq.logical && rq.dest != PHYS_BCAST)
        |=> $onehot0(out_mask));
    // R7
    self_only_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rq.sh == SH_SELF) |=> ($countones(out_mask) == 1
        && out_mask[$past(sender_idx)]));
    // R8
    all_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rq.sh == SH_ALL) |=> (&out_mask));
    // R8
    others_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rq.sh == SH_OTHERS) |=> (!out_mask[$past(sender_idx)]
        && $countones(out_mask) == N - 1));
    // R10
    pick_member_chk: assert property (@(posedge clk) disable iff (rst)
        out_pick_valid |-> out_mask[out_pick_idx]);
    // R10
    pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        out_pick_valid |-> ((out_mask & ((N'(1) << out_pick_idx) - N'(1))) == '0));
    // R10
    pick_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rq.dm != DM_LOWEST) |=> (!out_pick_valid && out_pick_idx == '0));
endmodule

// File: tb/irqdst_resolver_tb.sv
module irqdst_resolver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [31:0]   cmd_lo = '0;
    logic [31:0]   cmd_hi = '0;
    logic [IW-1:0] sender_idx = '0;
    logic [N*8-1:0] agent_id;
    logic [N*8-1:0] agent_ldest;
    logic [N*4-1:0] agent_model;
    logic           out_valid;
    logic [N-1:0]   out_mask;
    logic           out_pick_valid;
    logic [IW-1:0]  out_pick_idx;

    logic [7:0] cfg_id    [N];
    logic [7:0] cfg_ldest [N];
    logic [3:0] cfg_model [N];

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit chk_on  = 0;
    string tag  = "R11";

    logic          exp_valid = 0;
    logic [N-1:0]  exp_mask  = '0;
    logic          exp_pv    = 0;
    logic [IW-1:0] exp_pi    = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            agent_id[k*8 +: 8]    = cfg_id[k];
            agent_ldest[k*8 +: 8] = cfg_ldest[k];
            agent_model[k*4 +: 4] = cfg_model[k];
        end
    end

    irqdst_resolver #(.NUM_AGENTS(N), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .sender_idx(sender_idx),
        .agent_id(agent_id), .agent_ldest(agent_ldest), .agent_model(agent_model),
        .out_valid(out_valid), .out_mask(out_mask),
        .out_pick_valid(out_pick_valid), .out_pick_idx(out_pick_idx)
    );

    // Reference: which agents a message reaches.
    function automatic logic [N-1:0] ref_mask(input logic [31:0] lo, input logic [31:0] hi,
                                              input int snd);
        logic [N-1:0] m = '0;
        int sh = lo[19:18];
        int dst = hi[31:24];
        if (sh == 1) m[snd] = 1'b1;
        else if (sh == 2) m = '1;
        else if (sh == 3) begin m = '1; m[snd] = 1'b0; end
        else if (!lo[11]) begin
            if (dst == 255) m = '1;
            else begin
                for (int k = 0; k < N; k++)
                    if (cfg_id[k] == dst && m == '0) m[k] = 1'b1;
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                if (cfg_model[k] == 4'hF)
                    m[k] = (dst & cfg_ldest[k]) != 0;
                else if (cfg_model[k] == 4'h0)
                    m[k] = ((dst >> 4) == (cfg_ldest[k] >> 4)) && ((dst & cfg_ldest[k] & 15) != 0);
            end
        end
        return m;
    endfunction

    function automatic logic [63:0] mk(input int sh, input int dm, input int lg, input int dst);
        logic [31:0] lo, hi;
        lo = 32'hA0F0_005A;
        lo[19:18] = sh[1:0];
        lo[11]    = lg[0];
        lo[10:8]  = dm[2:0];
        hi = 32'h0055_AA33;
        hi[31:24] = dst[7:0];
        return {hi, lo};
    endfunction

    task automatic send(input logic [63:0] c, input int snd, input string t);
        logic [N-1:0] pm;
        logic pv;
        logic [IW-1:0] pi;
        @(negedge clk);
        cmd_lo = c[31:0]; cmd_hi = c[63:32]; sender_idx = IW'(snd); req_valid = 1'b1;
        pm = ref_mask(c[31:0], c[63:32], snd);
        pv = (c[10:8] == 3'd1) && (pm != '0);
        pi = '0;
        if (pv) for (int k = N - 1; k >= 0; k--) if (pm[k]) pi = IW'(k);
        @(posedge clk);
        #1;
        tag = t; exp_valid = 1'b1; exp_mask = pm; exp_pv = pv; exp_pi = pi;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cmd_lo = $urandom; cmd_hi = $urandom; sender_idx = IW'($urandom);
            @(posedge clk);
            #1;
            tag = "R1"; exp_valid = 1'b0;
        end
    endtask

    task automatic cmp(input string t);
        vectors++;
        if (out_valid !== exp_valid || out_mask !== exp_mask ||
            out_pick_valid !== exp_pv || out_pick_idx !== exp_pi) begin
            fails++;
            $display("FAIL %s: got v=%b m=%b pv=%b pi=%0d, expected v=%b m=%b pv=%b pi=%0d",
                     t, out_valid, out_mask, out_pick_valid, out_pick_idx,
                     exp_valid, exp_mask, exp_pv, exp_pi);
        end
    endtask

    always @(negedge clk) if (chk_on) cmp(tag);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // Agents 1 and 5 share ID 4; agent 6 has an unknown model.
        for (int k = 0; k < N; k++) cfg_id[k] = 8'(k * 3 + 1);
        cfg_id[5] = 8'd4;
        cfg_ldest[0] = 8'h01; cfg_ldest[1] = 8'h02; cfg_ldest[2] = 8'h04; cfg_ldest[3] = 8'h08;
        cfg_ldest[4] = 8'h21; cfg_ldest[5] = 8'h23; cfg_ldest[6] = 8'hFF; cfg_ldest[7] = 8'h10;
        cfg_model[0] = 4'hF; cfg_model[1] = 4'hF; cfg_model[2] = 4'hF; cfg_model[3] = 4'hF;
        cfg_model[4] = 4'h0; cfg_model[5] = 4'h0; cfg_model[6] = 4'h5; cfg_model[7] = 4'hF;

        repeat (3) @(posedge clk);
        #1;
        tag = "R11";
        @(negedge clk);
        cmp("R11");            // outputs cleared during reset
        rst = 1'b0;
        chk_on = 1;

        send(mk(0, 0, 0, 8'hFF), 0, "R2");        // physical broadcast
        send(mk(0, 1, 0, 8'd4),  0, "R3");        // duplicate ID: lowest agent 1
        send(mk(0, 0, 0, 8'd10), 0, "R3");        // agent 3
        send(mk(0, 1, 0, 8'h99), 0, "R3");        // no match, empty pick
        idle(3);
        send(mk(0, 0, 1, 8'h03), 0, "R4");        // flat agents 0,1
        send(mk(0, 0, 1, 8'h22), 0, "R5");        // cluster: agent 5 only
        send(mk(0, 0, 1, 8'h21), 0, "R5");        // cluster: agents 4,5
        send(mk(0, 0, 1, 8'hFF), 0, "R6");        // unknown model 6 excluded
        send(mk(1, 0, 0, 8'hFF), 2, "R7");        // self only
        send(mk(2, 0, 1, 8'h00), 5, "R8");        // all
        send(mk(3, 1, 0, 8'h00), 0, "R8");        // all but sender, pick 1
        send(mk(0, 1, 1, 8'h0C), 0, "R10");       // pick agent 2
        send(mk(0, 1, 1, 8'h40), 0, "R10");       // empty mask, no pick
        send(mk(0, 4, 1, 8'h0C), 0, "R10");       // other mode: no pick
        idle(2);
        send({32'hFFFF_FFFF & {8'h03, 24'hFFFFFF}, 32'hFFF3_F7FF & 32'hFFF3_F9FF}, 1, "R9");
        for (int i = 0; i < 300; i++) begin
            logic [63:0] c;
            c = {$urandom, $urandom};
            send(c, int'($urandom_range(0, N - 1)), "R9");
            if (i % 37 == 0) idle(1);
        end
        idle(2);
        @(negedge clk);
        chk_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule